// File: doc/BRIEF.md
# Consumer Digital Audio Serial Transmitter

This block turns stereo PCM samples into one self-clocking serial line that follows the consumer two-channel digital audio interface format. A two-bit source field picks the sample pair from one of three producers: a first decoder, a second decoder or a formatter. A width field says whether the producer delivers 16, 20 or 24 significant bits. The block always transmits 16 bits. Wider samples lose their low bits.

Each sample goes into a 32-slot subframe. A subframe holds a sync preamble, zero auxiliary bits, the audio field, and the validity, user, channel-status and parity bits. A left and a right subframe make one frame, and 192 frames make one channel-status block. The slots are biphase-mark encoded. One clock cycle is one half-cell, so the clock runs at 128 times the sample rate. The receiving side recovers its clock from the line. The block has no other output.

Top module: `spdif_tx`

## Requirements
- R1: While `rst_n` is low, `spdif_out` is low.
- R2: `src_sel` picks the sample pair: 0 picks the first decoder (`dec_a_l`/`dec_a_r`), 1 the second decoder (`dec_b_l`/`dec_b_r`), 2 the formatter (`fmt_l`/`fmt_r`), and 3 sends all-zero samples. The left subframe carries the left input and the right subframe carries the right input.
- R3: Samples arrive right-aligned in 24-bit ports. `width_sel` 0 transmits bits 15:0. `width_sel` 1 transmits bits 19:4, dropping 4 low bits. `width_sel` 2 or 3 transmits bits 23:8, dropping 8 low bits.
- R4: A subframe has 32 slots, numbered 0 to 31 in transmission order. Slots 4 to 11 are zero. Slots 12 to 27 carry the 16-bit sample, least significant bit first. Slot 28 carries `invalid_in` and slot 29 carries `user_in`.
- R5: Slot 31 is set so that slots 4 to 31 hold an even number of ones.
- R6: Slots 0 to 3 form a preamble of eight half-cells, first half-cell first. The preamble is 11101000 for the left subframe of frame 0 of a block, 11100010 for every other left subframe, and 11100100 for every right subframe. These patterns apply when the line was low before the preamble. They are inverted when it was high.
- R7: Each data slot (4 to 31) lasts two clock cycles. The line inverts at the start of every data slot and inverts again mid-slot only when the bit is 1.
- R8: Frames are counted 0 to 191 and then wrap. The frame-0 preamble appears exactly once every 192 frames.
- R9: Slot 30 of both subframes of frame k carries `cs_bits[k]` for k from 1 to 191. In frame 0 it is 0 whatever the value of `cs_bits[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cell clock, 128 times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Sample source select |
| width_sel | input | 2 | Significant width of the incoming samples |
| dec_a_l | input | 24 | First decoder, left sample |
| dec_a_r | input | 24 | First decoder, right sample |
| dec_b_l | input | 24 | Second decoder, left sample |
| dec_b_r | input | 24 | Second decoder, right sample |
| fmt_l | input | 24 | Formatter, left sample |
| fmt_r | input | 24 | Formatter, right sample |
| invalid_in | input | 1 | Value sent in the validity slot |
| user_in | input | 1 | Value sent in the user slot |
| cs_bits | input | 192 | Channel-status block, one bit per frame |
| spdif_out | output | 1 | Biphase-mark encoded serial line |

## Verification
If the half-cell counter is wrong, preambles land in the wrong place or are cut short. The decoder then finds a broken slot boundary or an unknown preamble within one 64-cycle subframe. If the parity or the line-level tracking is wrong, the line does not return to its starting level at the subframe end, and every following preamble is read as inverted. An error in the frame counter does not show within a frame: it shows only as a misplaced frame-0 preamble or a shifted channel-status bit, which takes up to one full 192-frame block (about 24,600 cycles) to observe.

// File: rtl/spdif_pkg.sv
package spdif_pkg;

  // sample and frame geometry
  localparam int SMP_W      = 24;
  localparam int OUT_W      = 16;
  localparam int AUD_W      = 20;
  localparam int SLOTS      = 32;
  localparam int PRE_SLOTS  = 4;
  localparam int FRAMES     = 192;
  localparam int HALVES     = 2 * SLOTS;
  localparam int HC_W       = $clog2(HALVES);
  localparam int FR_W       = $clog2(FRAMES);

  // slot positions inside a subframe
  localparam int AUD_LO     = 8;
  localparam int SMP_LO     = AUD_LO + AUD_W - OUT_W;
  localparam int V_SLOT     = AUD_LO + AUD_W;
  localparam int U_SLOT     = V_SLOT + 1;
  localparam int C_SLOT     = V_SLOT + 2;
  localparam int P_SLOT     = V_SLOT + 3;

  // sync patterns, first half-cell in bit 7, relative to a low line
  localparam logic [7:0] PRE_BLOCK = 8'b1110_1000;
  localparam logic [7:0] PRE_LEFT  = 8'b1110_0010;
  localparam logic [7:0] PRE_RIGHT = 8'b1110_0100;

  typedef enum logic [1:0] {
    SRC_DEC_A = 2'd0,
    SRC_DEC_B = 2'd1,
    SRC_FMT   = 2'd2,
    SRC_OFF   = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    WID_16  = 2'd0,
    WID_20  = 2'd1,
    WID_24  = 2'd2,
    WID_24X = 2'd3
  } wid_e;

endpackage

// File: rtl/spdif_src_mux.sv
module spdif_src_mux
  import spdif_pkg::*;
#(
  parameter int IN_W  = SMP_W,
  parameter int TX_W  = OUT_W,
  parameter int MID_DROP = 4
) (
  input  src_e            src_sel,
  input  wid_e            width_sel,
  input  logic [IN_W-1:0] dec_a_l,
  input  logic [IN_W-1:0] dec_a_r,
  input  logic [IN_W-1:0] dec_b_l,
  input  logic [IN_W-1:0] dec_b_r,
  input  logic [IN_W-1:0] fmt_l,
  input  logic [IN_W-1:0] fmt_r,
  output logic [TX_W-1:0] smp_l,
  output logic [TX_W-1:0] smp_r
);

  localparam int NCH = 2;

  logic [IN_W-1:0] raw  [NCH];
  logic [TX_W-1:0] trim [NCH];

  // source selection
  always_comb begin
    case (src_sel)
      SRC_DEC_A: begin raw[0] = dec_a_l; raw[1] = dec_a_r; end
      SRC_DEC_B: begin raw[0] = dec_b_l; raw[1] = dec_b_r; end
      SRC_FMT:   begin raw[0] = fmt_l;   raw[1] = fmt_r;   end
      default:   begin raw[0] = '0;      raw[1] = '0;      end
    endcase
  end

  // width reduction, one copy per channel
  for (genvar ch = 0; ch < NCH; ch++) begin : g_trim
    always_comb begin
      case (width_sel)
        WID_16:  trim[ch] = raw[ch][TX_W-1:0];
        WID_20:  trim[ch] = raw[ch][TX_W+MID_DROP-1:MID_DROP];
        default: trim[ch] = raw[ch][IN_W-1:IN_W-TX_W];
      endcase
    end
  end

  assign smp_l = trim[0];
  assign smp_r = trim[1];

endmodule

// File: rtl/spdif_framer.sv
module spdif_framer
  import spdif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OUT_W-1:0]  smp_l,
  input  logic [OUT_W-1:0]  smp_r,
  input  logic              invalid_in,
  input  logic              user_in,
  input  logic [FRAMES-1:0] cs_bits,
  output logic [HC_W-1:0]   hc,
  output logic              in_pre,
  output logic [7:0]        pre_code,
  output logic              data_bit
);

  logic [HC_W-1:0]  hc_q, hc_d;
  logic             right_q, right_d;
  logic [FR_W-1:0]  frame_q, frame_d;
  logic [OUT_W-1:0] smp_q, smp_d;
  logic             v_q, v_d, u_q, u_d, c_q, c_d;
  logic             sub_start, sub_end, frame_last;
  logic [SLOTS-1:0] word;

  assign sub_start  = (hc_q == '0);
  assign sub_end    = (hc_q == HC_W'(HALVES - 1));
  assign frame_last = (frame_q == FR_W'(FRAMES - 1));

  // next-state: position counters
  always_comb begin
    hc_d    = sub_end ? '0 : hc_q + 1'b1;
    right_d = right_q;
    frame_d = frame_q;
    if (sub_end) begin
      right_d = ~right_q;
      if (right_q) begin
        frame_d = frame_last ? '0 : frame_q + 1'b1;
      end
    end
  end

  // next-state: per-subframe payload capture
  always_comb begin
    smp_d = smp_q;
    v_d   = v_q;
    u_d   = u_q;
    c_d   = c_q;
    if (sub_start) begin
      smp_d = right_q ? smp_r : smp_l;
      v_d   = invalid_in;
      u_d   = user_in;
      c_d   = (frame_q == '0) ? 1'b0 : cs_bits[frame_q];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q    <= '0;
      right_q <= 1'b0;
      frame_q <= '0;
      smp_q   <= '0;
      v_q     <= 1'b0;
      u_q     <= 1'b0;
      c_q     <= 1'b0;
    end else begin
      hc_q    <= hc_d;
      right_q <= right_d;
      frame_q <= frame_d;
      smp_q   <= smp_d;
      v_q     <= v_d;
      u_q     <= u_d;
      c_q     <= c_d;
    end
  end

  // subframe word, slot 0 first
  always_comb begin
    word                 = '0;
    word[SMP_LO +: OUT_W] = smp_q;
    word[V_SLOT]         = v_q;
    word[U_SLOT]         = u_q;
    word[C_SLOT]         = c_q;
    word[P_SLOT]         = ^{smp_q, v_q, u_q, c_q};
  end

  assign hc       = hc_q;
  assign in_pre   = (hc_q < HC_W'(2 * PRE_SLOTS));
  assign data_bit = word[hc_q[HC_W-1:1]];
  assign pre_code = right_q ? PRE_RIGHT :
                    (frame_q == '0) ? PRE_BLOCK : PRE_LEFT;

  // R8
  frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_end && right_q) |=> (frame_q == (($past(frame_q) == FR_W'(FRAMES - 1)) ? '0 : $past(frame_q) + 1'b1)));

  // R6
  right_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sub_end) |=> $stable(right_q));

  // R4
  sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sub_start) |=> $stable(smp_q));

  // R9
  cs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_start && frame_q == '0) |=> !c_q);

endmodule

// File: rtl/spdif_bmc_enc.sv
module spdif_bmc_enc
  import spdif_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HC_W-1:0] hc,
  input  logic            in_pre,
  input  logic [7:0]      pre_code,
  input  logic            data_bit,
  output logic            line_out
);

  logic line_q, line_d;
  logic base_q, base_d;
  logic base_now, pat;

  // level the line held just before this subframe's preamble
  assign base_now = (hc == '0) ? line_q : base_q;
  assign pat      = pre_code[~hc[2:0]];

  always_comb begin
    base_d = base_now;
    if (in_pre) begin
      line_d = pat ^ base_now;
    end else if (!hc[0]) begin
      line_d = ~line_q;
    end else begin
      line_d = data_bit ? ~line_q : line_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      base_q <= 1'b0;
    end else begin
      line_q <= line_d;
      base_q <= base_d;
    end
  end

  assign line_out = line_q;

  // R5
  level_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hc == HC_W'(HALVES - 1)) |=> (line_q == base_q));

endmodule

// File: rtl/spdif_tx.sv
module spdif_tx
  import spdif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        src_sel,
  input  logic [1:0]        width_sel,
  input  logic [SMP_W-1:0]  dec_a_l,
  input  logic [SMP_W-1:0]  dec_a_r,
  input  logic [SMP_W-1:0]  dec_b_l,
  input  logic [SMP_W-1:0]  dec_b_r,
  input  logic [SMP_W-1:0]  fmt_l,
  input  logic [SMP_W-1:0]  fmt_r,
  input  logic              invalid_in,
  input  logic              user_in,
  input  logic [FRAMES-1:0] cs_bits,
  output logic              spdif_out
);

  logic [1:0]       rs_q, rs_d;
  logic             rst_int_n;
  logic [OUT_W-1:0] smp_l, smp_r;
  logic [HC_W-1:0]  hc;
  logic             in_pre, data_bit;
  logic [7:0]       pre_code;

  // reset: asserted at once, released on the clock
  assign rs_d = {rs_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= rs_d;
  end

  assign rst_int_n = rs_q[1];

  spdif_src_mux u_mux (
    .src_sel   (src_e'(src_sel)),
    .width_sel (wid_e'(width_sel)),
    .dec_a_l   (dec_a_l),
    .dec_a_r   (dec_a_r),
    .dec_b_l   (dec_b_l),
    .dec_b_r   (dec_b_r),
    .fmt_l     (fmt_l),
    .fmt_r     (fmt_r),
    .smp_l     (smp_l),
    .smp_r     (smp_r)
  );

  spdif_framer u_framer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .smp_l      (smp_l),
    .smp_r      (smp_r),
    .invalid_in (invalid_in),
    .user_in    (user_in),
    .cs_bits    (cs_bits),
    .hc         (hc),
    .in_pre     (in_pre),
    .pre_code   (pre_code),
    .data_bit   (data_bit)
  );

  spdif_bmc_enc u_bmc (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .hc       (hc),
    .in_pre   (in_pre),
    .pre_code (pre_code),
    .data_bit (data_bit),
    .line_out (spdif_out)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk) !rst_n |-> !spdif_out);

endmodule

// File: tb/spdif_tx_bench.sv
module spdif_tx_bench;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   src_sel, width_sel;
  logic [23:0]  dec_a_l, dec_a_r, dec_b_l, dec_b_r, fmt_l, fmt_r;
  logic         invalid_in, user_in;
  logic [191:0] cs_bits;
  logic         spdif_out;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;
  logic last_half;

  always #4 clk = ~clk;

  spdif_tx u_spdif_tx (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .width_sel(width_sel),
    .dec_a_l(dec_a_l), .dec_a_r(dec_a_r), .dec_b_l(dec_b_l), .dec_b_r(dec_b_r),
    .fmt_l(fmt_l), .fmt_r(fmt_r), .invalid_in(invalid_in), .user_in(user_in),
    .cs_bits(cs_bits), .spdif_out(spdif_out)
  );

  // {src_sel, width_sel, expected left, expected right}
  localparam int NV = 11;
  localparam logic [35:0] VEC [NV] = '{
    {2'd0, 2'd0, 16'hB2C3, 16'h2E3F},
    {2'd0, 2'd1, 16'h1B2C, 16'hD2E3},
    {2'd0, 2'd2, 16'hA1B2, 16'h1D2E},
    {2'd1, 2'd0, 16'h6789, 16'hDCBA},
    {2'd1, 2'd1, 16'h5678, 16'hEDCB},
    {2'd1, 2'd2, 16'h4567, 16'hFEDC},
    {2'd2, 2'd2, 16'h1357, 16'h2468},
    {2'd2, 2'd1, 16'h3579, 16'h468A},
    {2'd2, 2'd3, 16'h1357, 16'h2468},
    {2'd3, 2'd0, 16'h0000, 16'h0000},
    {2'd2, 2'd0, 16'h579B, 16'h68AC}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // align so that the next half-cell read starts a left subframe
  task automatic sync_stream();
    logic [8:0] hist = '0;
    bit found = 1'b0;
    for (int i = 0; i < 2000 && !found; i++) begin
      @(negedge clk);
      hist = {hist[7:0], spdif_out};
      if ((hist[7:0] ^ {8{hist[8]}}) == 8'b1110_0100) found = 1'b1;
    end
    check(found, "R6", "right preamble found for sync", 32'(found), 32'd1);
    for (int i = 0; i < 56; i++) @(negedge clk);
    last_half = spdif_out;
  endtask

  // read one subframe: kind 0 block, 1 left, 2 right, 3 unknown
  task automatic read_sub(output logic [31:0] w, output int kind, output int terr);
    logic h [64];
    logic [7:0] pre;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      h[i] = spdif_out;
    end
    for (int i = 0; i < 8; i++) pre[7-i] = h[i] ^ last_half;
    if      (pre == 8'b1110_1000) kind = 0;
    else if (pre == 8'b1110_0010) kind = 1;
    else if (pre == 8'b1110_0100) kind = 2;
    else                          kind = 3;
    w = '0;
    terr = 0;
    for (int k = 4; k < 32; k++) begin
      if (h[2*k] == h[2*k-1]) terr++;
      w[k] = (h[2*k] != h[2*k+1]);
    end
    last_half = h[63];
  endtask

  initial begin
    logic [31:0] wl, wr;
    int kl, kr, tl, tr;
    logic [15:0] el, er;
    rst_n = 1'b0;
    src_sel = 2'd0; width_sel = 2'd0;
    dec_a_l = 24'hA1B2C3; dec_a_r = 24'h1D2E3F;
    dec_b_l = 24'h456789; dec_b_r = 24'hFEDCBA;
    fmt_l   = 24'h13579B; fmt_r   = 24'h2468AC;
    invalid_in = 1'b0; user_in = 1'b0;
    cs_bits = '0;
    for (int k = 0; k < 192; k++) cs_bits[k] = (k % 3 == 0) || (k % 7 == 1);
    repeat (4) @(negedge clk);
    check(spdif_out == 1'b0, "R1", "line low in reset", 32'(spdif_out), 32'd0);
    rst_n = 1'b1;
    sync_stream();

    // table walk: source, width, layout, parity, preambles, encoding
    for (int v = 0; v < NV; v++) begin
      src_sel    = VEC[v][35:34];
      width_sel  = VEC[v][33:32];
      el         = VEC[v][31:16];
      er         = VEC[v][15:0];
      invalid_in = v[0];
      user_in    = v[1];
      read_sub(wl, kl, tl); read_sub(wr, kr, tr);
      read_sub(wl, kl, tl); read_sub(wr, kr, tr);
      check(wl[27:12] == el, "R2 R3", "left audio", 32'(wl[27:12]), 32'(el));
      check(wr[27:12] == er, "R2 R3", "right audio", 32'(wr[27:12]), 32'(er));
      check(wl[11:4] == 8'd0 && wr[11:4] == 8'd0 && wl[28] == v[0] && wl[29] == v[1]
            && wr[28] == v[0] && wr[29] == v[1],
            "R4", "zero slots, validity, user", {wl[29:28], wr[29:28], wl[11:4], wr[11:4]},
            {2'(v[1:0]), 2'(v[1:0]), 16'd0});
      check((^wl[31:4]) == 1'b0 && (^wr[31:4]) == 1'b0, "R5", "even parity",
            {wl[31], wr[31]}, 32'd0);
      check((kl == 0 || kl == 1) && kr == 2, "R6", "preamble kinds", {kl[15:0], kr[15:0]},
            32'h0001_0002);
      check(tl == 0 && tr == 0, "R7", "slot boundary transitions", tl + tr, 32'd0);
    end

    // block framing and channel status
    begin
      bit found = 1'b0;
      int berr = 0, cerr = 0;
      for (int f = 0; f < 200 && !found; f++) begin
        read_sub(wl, kl, tl); read_sub(wr, kr, tr);
        if (kl == 0) found = 1'b1;
      end
      check(found, "R8", "block preamble present", 32'(found), 32'd1);
      if (wl[30] != 1'b0 || wr[30] != 1'b0) cerr++;
      for (int k = 1; k <= 192; k++) begin
        read_sub(wl, kl, tl); read_sub(wr, kr, tr);
        if ((kl == 0) != (k == 192)) berr++;
        if (k < 192) begin
          if (wl[30] != cs_bits[k] || wr[30] != cs_bits[k]) cerr++;
        end else if (wl[30] != 1'b0 || wr[30] != 1'b0) begin
          cerr++;
        end
      end
      check(berr == 0, "R8", "block preamble spacing of 192 frames", berr, 32'd0);
      check(cerr == 0, "R9", "channel status per frame, frame 0 forced zero", cerr, 32'd0);
    end

    // reset mid-stream, then recover
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(spdif_out == 1'b0, "R1", "line low after mid-run reset", 32'(spdif_out), 32'd0);
    rst_n = 1'b1;
    sync_stream();
    src_sel = 2'd1; width_sel = 2'd1;
    read_sub(wl, kl, tl); read_sub(wr, kr, tr);
    read_sub(wl, kl, tl); read_sub(wr, kr, tr);
    check(wl[27:12] == 16'h5678 && wr[27:12] == 16'hEDCB, "R2", "audio after reset",
          {wl[27:12], wr[27:12]}, 32'h5678_EDCB);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule